// File: doc/BRIEF.md
# Streaming Linear-Chain Correlator

This block correlates an unsigned 8-bit sample stream against a set of NTAPS constant 8-bit weights. Each output is C[i] = sum over j = 0..NTAPS-1 of w[j]*A[i+j]. A[0] is the first sample of the current frame. The weights are written through a small write port while the block is idle. Samples then stream in with a valid/ready handshake, and results leave as a valid-qualified stream.

The products are not summed by an adder tree. They are merged along a linear chain of registered adders. Each new sample is multiplied by every weight and added to the partial sum that the chain stage to its left produced for the previous sample. No window of past samples is stored.

LANES sets how many multipliers are built. With LANES = NTAPS (full mode), every tap is updated in the cycle that a sample is accepted, so one sample is taken and one result produced per cycle. With LANES < NTAPS (partial mode), the taps are split into ceil(NTAPS/LANES) groups. The groups are updated over successive cycles, highest group first, so every chain stage reads the previous sample's finished partial sum from its neighbour. The input is held off for the extra cycles. The block is meant to be used in 3-, 5- and 11-tap configurations.

Top module: `linear_correlator`

## Requirements
- R1: Each result equals the sum over j = 0..NTAPS-1 of w[j]*A[i+j]. Samples and weights are unsigned 8-bit, and `out_data` is 16+ceil(log2 NTAPS) bits wide. This holds without overflow even when every sample and weight is 255.
- R2: A frame produces no result until its NTAPS-th sample is accepted. From then on, every accepted sample produces exactly one result. `out_valid` is high in the cycle that directly follows the clock edge that accepted the sample.
- R3: In full mode (LANES = NTAPS), `in_ready` stays high, so a sample can be accepted on every cycle.
- R4: In partial mode, `in_ready` drops for ceil(NTAPS/LANES)-1 cycles after each accepted sample. Samples held valid are therefore accepted exactly every ceil(NTAPS/LANES) cycles.
- R5: A sample accepted with `in_last` high is the last sample of its frame. The next accepted sample is A[0] of a new frame, and no result ever combines samples from two frames.
- R6: A write (`coef_we` high, `coef_addr` = tap index j, `coef_data` = w[j]) takes effect only while the block is idle. Idle means after reset, or after the last sample of a frame has finished all of its group passes. A write during a frame is dropped and the frame keeps its old weights.
- R7: Reset sets `out_valid` low, `in_ready` high, `out_data` to zero and every weight to zero. `out_data` holds its value in any cycle where `out_valid` is low.
- R8: Cycles with `in_valid` low do not advance the computation. A stream with idle gaps gives the same results, each one in the cycle after its sample was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | ceil(log2 NTAPS) | Tap index to write |
| coef_data | input | 8 | Unsigned weight value |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 8 | Unsigned sample |
| in_last | input | 1 | Marks the final sample of a frame |
| out_valid | output | 1 | Result valid this cycle |
| out_data | output | 16+ceil(log2 NTAPS) | Correlation result |

## Verification
The assertions check the following on every cycle:
- every result directly follows an accepted sample that filled the frame window;
- a filled window always yields a result on the next cycle;
- `out_data` holds while `out_valid` is low;
- `in_ready` drops after an acceptance only in partial mode, and never stays low longer than the group count allows.

Only the bench scenarios can show that the numbers are right. They compare results against sums computed in the bench, in full and partial mode and at the all-255 extreme. They also show that frames are separated by `in_last`, that weight writes during a frame are dropped and later ones are kept, and that idle gaps change nothing.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int SAMPLE_W = 8;
  localparam int COEF_W   = 8;
  localparam int PROD_W   = SAMPLE_W + COEF_W;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [COEF_W-1:0]   coef_t;
  typedef logic [PROD_W-1:0]   prod_t;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int LANES = NTAPS,
  localparam int G  = ceil_div(NTAPS, LANES),
  localparam int PW = (G > 1) ? $clog2(G) : 1,
  localparam int CW = $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          accept,
  output logic          step,
  output logic          fire,
  output logic          idle,
  output logic [PW-1:0] group
);
  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;

  assign in_ready = (ph == '0);
  assign accept   = in_valid && in_ready;
  assign step     = accept || (ph != '0);
  assign fire     = accept && (cnt == CW'(NTAPS - 1));
  assign idle     = (cnt == '0) && (ph == '0);
  // highest tap group first, so each stage reads a finished left neighbour
  assign group    = PW'(G - 1) - ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      cnt <= '0;
    end else begin
      if (accept)
        ph <= (G > 1) ? PW'(1) : '0;
      else if (ph != '0)
        ph <= (ph == PW'(G - 1)) ? '0 : ph + PW'(1);
      if (accept) begin
        if (in_last)
          cnt <= '0;
        else if (cnt != CW'(NTAPS - 1))
          cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/corr_coef_bank.sv
module corr_coef_bank
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  localparam int AW = $clog2(NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    wr_ok,
  input  logic [AW-1:0]           wr_addr,
  input  coef_t                   wr_data,
  output logic [NTAPS*COEF_W-1:0] coefs
);
  coef_t mem [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NTAPS; j++) mem[j] <= '0;
    end else if (wr_en && wr_ok && (int'(wr_addr) < NTAPS)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar j = 0; j < NTAPS; j++) begin : g_flat
    assign coefs[j*COEF_W +: COEF_W] = mem[j];
  end
endmodule

// File: rtl/corr_lane.sv
module corr_lane
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int LANES = NTAPS,
  parameter int IDX   = 0,
  parameter int PW    = 1
) (
  input  logic [NTAPS*COEF_W-1:0] coefs,
  input  logic [PW-1:0]           group,
  input  sample_t                 x,
  output prod_t                   prod
);
  coef_t c;

  always_comb begin
    int tap;
    tap = int'(group) * LANES + IDX;
    c = '0;
    if (tap < NTAPS) c = coefs[tap*COEF_W +: COEF_W];
  end

  assign prod = {{SAMPLE_W{1'b0}}, c} * {{COEF_W{1'b0}}, x};
endmodule

// File: rtl/corr_chain.sv
module corr_chain
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int LANES = NTAPS,
  parameter int PW    = 1,
  parameter int OW    = 19
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic [PW-1:0]           group,
  input  logic [LANES*PROD_W-1:0] prods,
  output logic [OW-1:0]           tail_next
);
  logic [OW-1:0] nxt [NTAPS];
  logic [OW-1:0] st  [NTAPS-1];

  for (genvar j = 0; j < NTAPS; j++) begin : g_stage
    localparam int GJ = j / LANES;
    localparam int LJ = j % LANES;
    if (j == 0) begin : g_head
      assign nxt[j] = OW'(prods[LJ*PROD_W +: PROD_W]);
    end else begin : g_link
      assign nxt[j] = st[j-1] + OW'(prods[LJ*PROD_W +: PROD_W]);
    end
    if (j < NTAPS - 1) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          st[j] <= '0;
        else if (step && (group == PW'(GJ)))
          st[j] <= nxt[j];
      end
    end
  end

  assign tail_next = nxt[NTAPS-1];
endmodule

// File: rtl/linear_correlator.sv
module linear_correlator
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int LANES = NTAPS,
  localparam int AW = $clog2(NTAPS),
  localparam int OW = PROD_W + $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [7:0]    coef_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int G  = ceil_div(NTAPS, LANES);
  localparam int PW = (G > 1) ? $clog2(G) : 1;

  logic                    accept, step, fire, idle;
  logic [PW-1:0]           group;
  logic [NTAPS*COEF_W-1:0] coefs;
  logic [LANES*PROD_W-1:0] prods;
  logic [OW-1:0]           tail_next;
  sample_t                 x_hold, x_cur;

  corr_ctrl #(.NTAPS(NTAPS), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .accept(accept), .step(step), .fire(fire),
    .idle(idle), .group(group)
  );

  corr_coef_bank #(.NTAPS(NTAPS)) u_coef (
    .clk(clk), .rst(rst), .wr_en(coef_we), .wr_ok(idle),
    .wr_addr(coef_addr), .wr_data(coef_data), .coefs(coefs)
  );

  assign x_cur = in_ready ? in_data : x_hold;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    corr_lane #(.NTAPS(NTAPS), .LANES(LANES), .IDX(l), .PW(PW)) u_lane (
      .coefs(coefs), .group(group), .x(x_cur),
      .prod(prods[l*PROD_W +: PROD_W])
    );
  end

  corr_chain #(.NTAPS(NTAPS), .LANES(LANES), .PW(PW), .OW(OW)) u_chain (
    .clk(clk), .rst(rst), .step(step), .group(group),
    .prods(prods), .tail_next(tail_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_hold    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) x_hold <= in_data;
      out_valid <= fire;
      if (fire) out_data <= tail_next;
    end
  end
endmodule

// File: rtl/corr_checker.sv
module corr_checker
  import corr_pkg::*;
#(
  parameter int NTAPS = 5,
  parameter int LANES = NTAPS,
  parameter int OW    = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  localparam int G = ceil_div(NTAPS, LANES);

  logic       acc;
  int         seen;
  logic [7:0] low_run;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 0;
      low_run <= '0;
    end else begin
      if (acc) seen <= in_last ? 0 : ((seen == NTAPS - 1) ? seen : seen + 1);
      low_run <= in_ready ? '0 : low_run + 8'd1;
    end
  end

  AST_OUT_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(acc) && ($past(seen) == NTAPS - 1))); // R2
  AST_FILL_GIVES_OUT: assert property (@(posedge clk) disable iff (rst)
    (acc && (seen == NTAPS - 1)) |=> out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R7
  AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    acc |=> (in_ready == (G == 1))); // R3
  AST_READY_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (int'(low_run) < G - 1)); // R4
endmodule

bind linear_correlator corr_checker #(.NTAPS(NTAPS), .LANES(LANES), .OW(OW)) u_corr_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_linear_correlator.sv
module tb_linear_correlator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // dut: 5 taps, full mode; dut_p: 11 taps on 3 lanes (4 group passes)
  logic we0 = 0, iv0 = 0, il0 = 0, ir0, ov0;
  logic [2:0] ad0 = '0;
  logic [7:0] cd0 = '0, id0 = '0;
  logic [18:0] od0;
  logic we1 = 0, iv1 = 0, il1 = 0, ir1, ov1;
  logic [3:0] ad1 = '0;
  logic [7:0] cd1 = '0, id1 = '0;
  logic [19:0] od1;

  linear_correlator #(.NTAPS(5), .LANES(5)) dut (
    .clk(clk), .rst(rst), .coef_we(we0), .coef_addr(ad0), .coef_data(cd0),
    .in_valid(iv0), .in_ready(ir0), .in_data(id0), .in_last(il0),
    .out_valid(ov0), .out_data(od0));
  linear_correlator #(.NTAPS(11), .LANES(3)) dut_p (
    .clk(clk), .rst(rst), .coef_we(we1), .coef_addr(ad1), .coef_data(cd1),
    .in_valid(iv1), .in_ready(ir1), .in_data(id1), .in_last(il1),
    .out_valid(ov1), .out_data(od1));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int w0 [5];
  int w1 [11];
  int samp [64];
  int acyc [64];
  int got [64];
  int gcyc [64];
  int ngot = 0, hold_bad = 0, watch = 0;
  logic [19:0] prev0 = '0, prev1 = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // collect results of the DUT under test (watch selects it); track hold of both
  always @(negedge clk) begin
    if (!rst) begin
      if (!ov0 && (20'(od0) != prev0)) hold_bad++;
      if (!ov1 && (od1 != prev1)) hold_bad++;
      if ((watch == 0 && ov0) || (watch == 1 && ov1)) begin
        if (ngot < 64) begin
          got[ngot]  = (watch == 0) ? int'(od0) : int'(od1);
          gcyc[ngot] = cyc;
        end
        ngot++;
      end
    end
    prev0 = 20'(od0);
    prev1 = od1;
  end

  function automatic int ntaps(input int d);
    return (d == 0) ? 5 : 11;
  endfunction

  task automatic wr(input int d, input int a, input int v);
    if (d == 0) begin we0 = 1; ad0 = 3'(a); cd0 = 8'(v); end
    else begin we1 = 1; ad1 = 4'(a); cd1 = 8'(v); end
    @(negedge clk);
    we0 = 0; we1 = 0;
  endtask

  task automatic load(input int d, input int base, input int stepv);
    for (int j = 0; j < ntaps(d); j++) begin
      int v;
      v = (base + j * stepv) % 256;
      wr(d, j, v);
      if (d == 0) w0[j] = v; else w1[j] = v;
    end
  endtask

  function automatic int pat(input int mode, input int i);
    case (mode)
      0: return i + 1;
      1: return (i * 37 + 11) % 256;
      default: return 255;
    endcase
  endfunction

  // send one frame; gap inserts idle cycles; cw_at >= 0 pulses a weight write at that sample
  task automatic send(input int d, input int n, input int mode, input bit gap,
                      input int cw_at, input int cw_val);
    watch = d;
    ngot = 0;
    for (int i = 0; i < n; i++) begin
      samp[i] = pat(mode, i);
      if (d == 0) begin iv0 = 1; id0 = 8'(samp[i]); il0 = (i == n - 1); end
      else begin iv1 = 1; id1 = 8'(samp[i]); il1 = (i == n - 1); end
      if (i == cw_at) begin
        if (d == 0) begin we0 = 1; ad0 = 3'd2; cd0 = 8'(cw_val); end
        else begin we1 = 1; ad1 = 4'd2; cd1 = 8'(cw_val); end
      end
      while ((d == 0) ? !ir0 : !ir1) @(negedge clk);
      @(negedge clk);
      we0 = 0; we1 = 0;
      acyc[i] = cyc;
      iv0 = 0; iv1 = 0; il0 = 0; il1 = 0;
      if (gap) repeat (i % 3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic check_frame(input int d, input int n, input string req);
    int nt, cnt;
    nt = ntaps(d);
    cnt = (n >= nt) ? n - nt + 1 : 0;
    chk(ngot == cnt, {req, " result count"}, ngot, cnt);
    for (int i = 0; i < cnt && i < ngot; i++) begin
      int e;
      e = 0;
      for (int j = 0; j < nt; j++) e += ((d == 0) ? w0[j] : w1[j]) * samp[i + j];
      chk(got[i] == e, {req, " value"}, got[i], e);
      chk(gcyc[i] == acyc[i + nt - 1], "R2 result cycle", gcyc[i], acyc[i + nt - 1]);
    end
  endtask

  task automatic t_reset;
    chk(ir0 == 1'b1, "R7 ready after reset", int'(ir0), 1);
    chk(ir1 == 1'b1, "R7 ready after reset", int'(ir1), 1);
    chk(ov0 == 1'b0, "R7 valid after reset", int'(ov0), 0);
    chk(ov1 == 1'b0, "R7 valid after reset", int'(ov1), 0);
    chk(od0 == '0, "R7 data after reset", int'(od0), 0);
    for (int j = 0; j < 5; j++) w0[j] = 0;
    send(0, 6, 0, 0, -1, 0);
    check_frame(0, 6, "R7 zero weights");
  endtask

  task automatic t_full_stream;
    load(0, 3, 7);
    send(0, 12, 0, 0, -1, 0);
    check_frame(0, 12, "R1 full mode");
    for (int i = 1; i < 12; i++)
      chk(acyc[i] - acyc[i-1] == 1, "R3 one sample per cycle", acyc[i] - acyc[i-1], 1);
  endtask

  task automatic t_gaps;
    send(0, 10, 1, 1, -1, 0);
    check_frame(0, 10, "R8 gapped stream");
  endtask

  task automatic t_max;
    load(0, 255, 0);
    send(0, 7, 2, 0, -1, 0);
    check_frame(0, 7, "R1 all-255 no overflow");
  endtask

  task automatic t_frames;
    load(0, 9, 13);
    send(0, 8, 1, 0, -1, 0);
    check_frame(0, 8, "R5 first frame");
    send(0, 7, 0, 1, -1, 0);
    check_frame(0, 7, "R5 second frame");
    send(0, 3, 1, 0, -1, 0);
    check_frame(0, 3, "R2 short frame silent");
    send(0, 5, 0, 0, -1, 0);
    check_frame(0, 5, "R5 frame after short frame");
  endtask

  task automatic t_coef_busy;
    load(0, 2, 5);
    send(0, 9, 1, 0, 3, 200);
    check_frame(0, 9, "R6 write during frame dropped");
    wr(0, 2, 200);
    w0[2] = 200;
    send(0, 9, 1, 0, -1, 0);
    check_frame(0, 9, "R6 idle write kept");
  endtask

  task automatic t_partial;
    load(1, 17, 23);
    send(1, 15, 1, 0, -1, 0);
    check_frame(1, 15, "R1 partial mode");
    for (int i = 1; i < 15; i++)
      chk(acyc[i] - acyc[i-1] == 4, "R4 issue interval", acyc[i] - acyc[i-1], 4);
    send(1, 13, 0, 1, -1, 0);
    check_frame(1, 13, "R8 partial gapped");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_full_stream();
    t_gaps();
    t_max();
    t_frames();
    t_coef_busy();
    t_partial();
    chk(hold_bad == 0, "R7 output hold", hold_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule